// File: doc/BRIEF.md
# Windowed Outbound Address Translator

This block translates CPU-side addresses through a set of programmable windows, which are reached through an indirect register scheme. There are two sets of windows, outbound and inbound, with NWIN windows in each set. A single selector register chooses a direction and an index. Seven fixed offsets then read and write that window's controls, base, limit and target.

The block stages settings as they are written. A window only takes its new settings for matching when its second control word is written. Every enabled outbound window compares the probe address against its range. The lowest-numbered window that matches produces the result. A memory window gives a relocated address. A configuration window gives a bus number, a device/function number and a register offset, all taken from its target. Inbound windows keep their register state but never translate probe addresses.

Top module: `vat_xlate`

## Requirements
- R1: Writing offset 0x900 stores only bit 31 (1 = inbound set, 0 = outbound set) and the low log2(NWIN) index bits. Every other bit reads back as 0.
- R2: The window picked by the selector exposes its registers at these offsets: control word A at 0x904, control word B at 0x908, base low at 0x90C, base high at 0x910, limit at 0x914, target low at 0x918 and target high at 0x91C. Each window keeps its own values.
- R3: After reset, every window reads base 0, target 0, limit 0xFFFFFFFF, control A 0 and control B 0. The one exception is inbound window 0, whose control B reads 0x80000000.
- R4: Writes to base, limit, target or control A change nothing in translation until control B of that window is written.
- R5: Control B bit 31 enables a window for matching. A window committed with bit 31 clear never hits.
- R6: A committed memory window (control A equal to 0) hits when base <= addr <= {base[63:32], limit}. On a hit the output address is target + (addr - base).
- R7: A committed window whose control A is nonzero is a configuration window. On a hit it asserts xl_cfg and drives xl_bus = target[31:23+1] (bits 31:24) and xl_devfn = target[23:16]. The output address is the low 12 bits of addr - base, zero-extended.
- R8: When no window hits, xl_hit and xl_cfg are 0, the address passes through unchanged, and bus and devfn are 0.
- R9: When several enabled windows match, the lowest window number wins. xl_win reports that number.
- R10: Inbound windows never produce a hit, even the inbound window 0 that is enabled at reset.
- R11: A read at any offset outside 0x900 to 0x91C returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| xl_addr | input | 64 | Probe address to translate |
| xl_hit | output | 1 | Some outbound window matched |
| xl_cfg | output | 1 | The winning window is a configuration window |
| xl_addr_out | output | 64 | Translated address, or offset, or passthrough |
| xl_bus | output | 8 | Bus number for a configuration hit |
| xl_devfn | output | 8 | Device/function number for a configuration hit |
| xl_win | output | $clog2(2*NWIN) | Winning window number (outbound windows are 0..NWIN-1) |

## Verification
The hardest state to reach is the gap between staging and committing. In that gap a window holds new base, limit and target values in its visible registers, while matching still runs on the old committed copy. The stimulus first commits every outbound window as disabled. It then stages a full new range on one window and probes inside that range before and after the control B write. A second hard case is overlap: two enabled windows are programmed so they share part of their range, and probes in the shared part must resolve to the lower window. Probes are swept across each window at one below the base, the base, one above the base, one below the end, the end and one beyond the end.

// File: rtl/vat_pkg.sv
package vat_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_VIEW, RS_CTLA, RS_CTLB, RS_BLO, RS_BHI, RS_LIM, RS_TLO, RS_THI
  } vat_reg_e;

  function automatic vat_reg_e vat_decode(input logic [11:0] a);
    case (a)
      12'h900: return RS_VIEW;
      12'h904: return RS_CTLA;
      12'h908: return RS_CTLB;
      12'h90C: return RS_BLO;
      12'h910: return RS_BHI;
      12'h914: return RS_LIM;
      12'h918: return RS_TLO;
      12'h91C: return RS_THI;
      default: return RS_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vat_window.sv
module vat_window
  import vat_pkg::*;
#(
  parameter bit IS_OUT    = 1'b1,
  parameter bit EN_AT_RST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  vat_reg_e    wr_sel,
  input  logic [31:0] wr_data,
  output logic [63:0] base_q,
  output logic [31:0] limit_q,
  output logic [63:0] target_q,
  output logic [31:0] ctla_q,
  output logic [31:0] ctlb_q,
  output logic [63:0] act_base_q,
  output logic [63:0] act_target_q,
  output logic        act_cfg_q,
  input  logic [63:0] probe,
  output logic        match
);

  logic [63:0] base_d, target_d, act_base_d, act_target_d, act_end_d, act_end_q;
  logic [31:0] limit_d, ctla_d, ctlb_d;
  logic        act_cfg_d, act_en_d, act_en_q, commit;

  always_comb begin
    base_d   = base_q;
    limit_d  = limit_q;
    target_d = target_q;
    ctla_d   = ctla_q;
    ctlb_d   = ctlb_q;
    commit   = 1'b0;
    if (wr_en) begin
      case (wr_sel)
        RS_CTLA: ctla_d = wr_data;
        RS_CTLB: begin ctlb_d = wr_data; commit = 1'b1; end
        RS_BLO:  base_d[31:0]    = wr_data;
        RS_BHI:  base_d[63:32]   = wr_data;
        RS_LIM:  limit_d         = wr_data;
        RS_TLO:  target_d[31:0]  = wr_data;
        RS_THI:  target_d[63:32] = wr_data;
        default: ;
      endcase
    end
    act_base_d   = base_q;
    act_end_d    = {base_q[63:32], limit_q};
    act_target_d = target_q;
    act_cfg_d    = (ctla_q != 32'd0);
    act_en_d     = wr_data[31];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      limit_q  <= 32'hFFFF_FFFF;
      target_q <= '0;
      ctla_q   <= '0;
      ctlb_q   <= {EN_AT_RST, 31'd0};
    end else if (wr_en) begin
      base_q   <= base_d;
      limit_q  <= limit_d;
      target_q <= target_d;
      ctla_q   <= ctla_d;
      ctlb_q   <= ctlb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_base_q   <= '0;
      act_end_q    <= 64'h0000_0000_FFFF_FFFF;
      act_target_q <= '0;
      act_cfg_q    <= 1'b0;
      act_en_q     <= EN_AT_RST;
    end else if (commit) begin
      act_base_q   <= act_base_d;
      act_end_q    <= act_end_d;
      act_target_q <= act_target_d;
      act_cfg_q    <= act_cfg_d;
      act_en_q     <= act_en_d;
    end
  end

  assign match = IS_OUT && act_en_q && (probe >= act_base_q) && (probe <= act_end_q);

  assert_stage_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel != RS_CTLB) |=> ($stable(act_base_q) && $stable(act_end_q)
                                      && $stable(act_target_q) && $stable(act_en_q)));

  assert_enable_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == RS_CTLB) |=> (act_en_q == $past(wr_data[31])));

  assert_inbound_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !IS_OUT |-> !match);

endmodule

// File: rtl/vat_pick.sv
module vat_pick #(
  parameter int M  = 8,
  localparam int IW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [M-1:0]  hit,
  output logic [M-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    idx = '0;
    for (int i = M - 1; i >= 0; i--) begin
      if (hit[i]) idx = IW'(i);
    end
    any   = |hit;
    grant = any ? (M'(1) << idx) : '0;
  end

  assert_onehot_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~hit) == '0));

  assert_lowest_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (((grant - M'(1)) & hit) == '0));

endmodule

// File: rtl/vat_xlate.sv
module vat_xlate
  import vat_pkg::*;
#(
  parameter int NWIN = 4,
  localparam int M  = 2 * NWIN,
  localparam int IW = $clog2(M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [63:0]   xl_addr,
  output logic          xl_hit,
  output logic          xl_cfg,
  output logic [63:0]   xl_addr_out,
  output logic [7:0]    xl_bus,
  output logic [7:0]    xl_devfn,
  output logic [IW-1:0] xl_win
);

  localparam int VW = $clog2(NWIN);
  localparam logic [31:0] VP_MASK = 32'h8000_0000 | 32'(NWIN - 1);

  vat_reg_e    reg_sel;
  logic [31:0] vp_q, vp_d;
  logic [IW-1:0] cur;

  logic [63:0] w_base [M];
  logic [31:0] w_lim  [M];
  logic [63:0] w_tgt  [M];
  logic [31:0] w_ca   [M];
  logic [31:0] w_cb   [M];
  logic [63:0] w_abase[M];
  logic [63:0] w_atgt [M];
  logic [M-1:0] w_acfg;
  logic [M-1:0] w_hit;
  logic [M-1:0] grant;
  logic [IW-1:0] pick;
  logic          any;
  logic [63:0]   off;

  assign reg_sel = vat_decode(reg_addr);
  assign cur     = {vp_q[31], vp_q[VW-1:0]};

  always_comb begin
    vp_d = vp_q;
    if (reg_we && reg_sel == RS_VIEW) vp_d = reg_wdata & VP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        vp_q <= '0;
    else if (reg_we && reg_sel == RS_VIEW) vp_q <= vp_d;
  end

  for (genvar w = 0; w < M; w++) begin : g_win
    vat_window #(
      .IS_OUT   (w < NWIN),
      .EN_AT_RST(w == NWIN)
    ) win_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (reg_we && (cur == IW'(w))),
      .wr_sel      (reg_sel),
      .wr_data     (reg_wdata),
      .base_q      (w_base[w]),
      .limit_q     (w_lim[w]),
      .target_q    (w_tgt[w]),
      .ctla_q      (w_ca[w]),
      .ctlb_q      (w_cb[w]),
      .act_base_q  (w_abase[w]),
      .act_target_q(w_atgt[w]),
      .act_cfg_q   (w_acfg[w]),
      .probe       (xl_addr),
      .match       (w_hit[w])
    );
  end

  always_comb begin
    case (reg_sel)
      RS_VIEW: reg_rdata = vp_q;
      RS_CTLA: reg_rdata = w_ca[cur];
      RS_CTLB: reg_rdata = w_cb[cur];
      RS_BLO:  reg_rdata = w_base[cur][31:0];
      RS_BHI:  reg_rdata = w_base[cur][63:32];
      RS_LIM:  reg_rdata = w_lim[cur];
      RS_TLO:  reg_rdata = w_tgt[cur][31:0];
      RS_THI:  reg_rdata = w_tgt[cur][63:32];
      default: reg_rdata = '0;
    endcase
  end

  vat_pick #(.M(M)) pick_i (
    .clk  (clk),
    .rst_n(rst_n),
    .hit  (w_hit),
    .grant(grant),
    .idx  (pick),
    .any  (any)
  );

  always_comb begin
    off      = xl_addr - w_abase[pick];
    xl_hit   = any;
    xl_cfg   = any && w_acfg[pick];
    xl_win   = pick;
    xl_bus   = xl_cfg ? w_atgt[pick][31:24] : 8'd0;
    xl_devfn = xl_cfg ? w_atgt[pick][23:16] : 8'd0;
    if (!any)        xl_addr_out = xl_addr;
    else if (xl_cfg) xl_addr_out = {52'd0, off[11:0]};
    else             xl_addr_out = w_atgt[pick] + off;
  end

  assert_view_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == RS_VIEW) |=> (vp_q == ($past(reg_wdata) & VP_MASK)));

  assert_miss_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_hit |-> (xl_addr_out == xl_addr && !xl_cfg));

  assert_cfg_needs_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xl_cfg |-> (xl_hit && xl_addr_out[63:12] == '0));

endmodule

// File: tb/vat_xlate_tb.sv
module vat_xlate_tb_top;

  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] xl_addr = '0;
  logic        xl_hit, xl_cfg;
  logic [63:0] xl_addr_out;
  logic [7:0]  xl_bus, xl_devfn;
  logic [2:0]  xl_win;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic        m_en  [NW];
  logic [63:0] m_base[NW];
  logic [63:0] m_end [NW];
  logic [63:0] m_tgt [NW];
  logic        m_cfg [NW];

  always #2 clk = ~clk;

  vat_xlate #(.NWIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xl_addr(xl_addr),
    .xl_hit(xl_hit), .xl_cfg(xl_cfg), .xl_addr_out(xl_addr_out),
    .xl_bus(xl_bus), .xl_devfn(xl_devfn), .xl_win(xl_win)
  );

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, {32'd0, reg_rdata}, {32'd0, exp});
  endtask

  task automatic probe(logic [63:0] a, string tag);
    logic hit, cfg;
    logic [63:0] eo;
    logic [7:0] eb, ed;
    logic [2:0] ew;
    hit = 0; cfg = 0; eo = a; eb = 0; ed = 0; ew = 0;
    for (int j = 0; j < NW; j++) begin
      if (!hit && m_en[j] && a >= m_base[j] && a <= m_end[j]) begin
        hit = 1; ew = 3'(j); cfg = m_cfg[j];
        if (cfg) begin
          eo = {52'd0, 12'(a - m_base[j])};
          eb = m_tgt[j][31:24]; ed = m_tgt[j][23:16];
        end else eo = m_tgt[j] + (a - m_base[j]);
      end
    end
    @(negedge clk);
    xl_addr = a;
    #1;
    chk({tag, " hit"}, {63'd0, xl_hit}, {63'd0, hit});
    chk({tag, " cfg"}, {63'd0, xl_cfg}, {63'd0, cfg});
    chk({tag, " addr"}, xl_addr_out, eo);
    chk({tag, " bus"}, {56'd0, xl_bus}, {56'd0, eb});
    chk({tag, " devfn"}, {56'd0, xl_devfn}, {56'd0, ed});
    if (hit) chk({tag, " win"}, {61'd0, xl_win}, {61'd0, ew});
  endtask

  task automatic prog(int j, logic [63:0] b, logic [31:0] l, logic [63:0] t,
                      logic [31:0] ca, logic [31:0] cb);
    wr(12'h900, 32'(j));
    wr(12'h90C, b[31:0]);  wr(12'h910, b[63:32]);
    wr(12'h914, l);
    wr(12'h918, t[31:0]);  wr(12'h91C, t[63:32]);
    wr(12'h904, ca);
    wr(12'h908, cb);
    m_en[j] = cb[31]; m_base[j] = b; m_end[j] = {b[63:32], l};
    m_tgt[j] = t; m_cfg[j] = (ca != 0);
  endtask

  task automatic sweep(int j, string tag);
    probe(m_base[j] - 1, tag); probe(m_base[j], tag); probe(m_base[j] + 1, tag);
    probe(m_end[j] - 1, tag);  probe(m_end[j], tag);  probe(m_end[j] + 1, tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int j = 0; j < NW; j++) begin
      m_en[j] = 0; m_base[j] = 0; m_end[j] = 0; m_tgt[j] = 0; m_cfg[j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset values across both sets
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < NW; i++) begin
        wr(12'h900, {d[0], 31'(i)});
        rd(12'h90C, 32'd0, "R3 base lo");
        rd(12'h914, 32'hFFFF_FFFF, "R3 limit");
        rd(12'h91C, 32'd0, "R3 target hi");
        rd(12'h904, 32'd0, "R3 ctl A");
        rd(12'h908, (d == 1 && i == 0) ? 32'h8000_0000 : 32'd0, "R3 ctl B");
      end
    end

    // R10: inbound window 0 is enabled but never translates; R8 passthrough
    probe(64'h0, "R10 zero");
    probe(64'h1234_5678, "R10 mid");
    probe(64'hFFFF_FFFF, "R8 top");

    // R1: selector masking
    wr(12'h900, 32'hFFFF_FFFF);
    rd(12'h900, 32'h8000_0003, "R1 mask all");
    wr(12'h900, 32'h7FFF_FFF6);
    rd(12'h900, 32'h0000_0002, "R1 mask low");

    // R11: unmapped reads
    rd(12'h000, 32'd0, "R11 zero offset");
    rd(12'h920, 32'd0, "R11 past end");
    rd(12'h8FC, 32'd0, "R11 before start");

    // R2: per-window storage sweep
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < NW; i++) begin
        wr(12'h900, {d[0], 31'(i)});
        for (int r = 1; r < 8; r++)
          wr(12'(12'h900 + 4 * r), 32'hA000_005A ^ (d << 20) ^ (i << 16) ^ (r << 8));
      end
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < NW; i++) begin
        wr(12'h900, {d[0], 31'(i)});
        for (int r = 1; r < 8; r++)
          rd(12'(12'h900 + 4 * r), 32'hA000_005A ^ (d << 20) ^ (i << 16) ^ (r << 8),
             "R2 readback");
      end

    // R5: commit all outbound windows disabled
    for (int i = 0; i < NW; i++) begin
      wr(12'h900, 32'(i));
      wr(12'h908, 32'h0);
    end
    probe(64'hA000_005A, "R5 disabled");

    // R4: staged but not committed
    wr(12'h900, 32'd0);
    wr(12'h90C, 32'h0000_1000); wr(12'h910, 32'h1);
    wr(12'h914, 32'h0000_1FFF);
    wr(12'h918, 32'h0); wr(12'h91C, 32'h80);
    wr(12'h904, 32'h0);
    probe(64'h1_0000_1800, "R4 before commit");
    prog(0, 64'h1_0000_1000, 32'h0000_1FFF, 64'h80_0000_0000, 32'h0, 32'h8000_0000);
    probe(64'h1_0000_1800, "R4 after commit");

    // R6, R9: overlapping memory window
    prog(1, 64'h1_0000_1800, 32'h0000_2FFF, 64'h4000, 32'h0, 32'h8000_0000);
    // R7: configuration window
    prog(2, 64'h2000_0000, 32'h2000_FFFF, 64'h0512_0000, 32'h4, 32'h8000_0000);
    // R5: window staged with enable clear
    prog(3, 64'h3000_0000, 32'h3000_0FFF, 64'h9000, 32'h0, 32'h0000_0001);

    sweep(0, "R6 w0");
    sweep(1, "R9 w1 overlap");
    probe(64'h1_0000_1FFF, "R9 shared end");
    sweep(2, "R7 cfg");
    probe(64'h2000_1234, "R7 cfg offset");
    sweep(3, "R5 off");
    probe(64'h5555_0000, "R8 miss");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule